// File: doc/BRIEF.md
# Character Display Instruction Decoder

This block is the controller for a two-line, sixteen-column character display. A host drives a parallel bus port (register select, read/write select, an 8-bit data byte and a one-cycle strobe). The block decodes instruction writes, RAM data writes and reads, and busy/address reads. It holds an 80-byte display RAM and a 64-byte glyph RAM. A single address counter points into whichever RAM was last selected by an address-set instruction. The block also keeps the mode flags, a display shift offset that is separate from the address counter, and a busy countdown whose length depends on the command.

After an accepted command the block stays busy for a fixed number of internal clock cycles. During that time it ignores everything on the bus except a busy/address read. The display-side flags and the shift offset are brought out as ports for the renderer. Font lookup and panel drive are not part of this block.

Top module: `chardisp_top`

## Requirements
- R1: With select=0 and read/write=0, the command is the highest set data bit: bit7 sets the display address to bits 6:0; bit6 sets the glyph address to bits 5:0; bit5 is function set, where bit3 set means two-line mode; bit4 is shift, with bit3 selecting display (1) or cursor (0) and bit2 selecting right (1) or left (0); bit3 is display control, with bit2 display, bit1 cursor and bit0 blink; bit2 is entry mode, with bit1 increment and bit0 shift-on-write; bit1 is home; bit0 is clear. A byte of 00h does nothing and does not set busy.
- R2: Clear writes 20h to all 80 display RAM bytes, sets the address to 00h in display RAM, sets the shift offset to 0 and forces increment mode.
- R3: Home sets the address to 00h in display RAM and the shift offset to 0, and leaves RAM contents unchanged.
- R4: In two-line mode the display address steps 27h→40h and 67h→00h when incrementing, and 40h→27h and 00h→67h when decrementing.
- R5: In one-line mode the display address steps 4Fh→00h and 00h→4Fh. Glyph addresses wrap modulo 64.
- R6: A cursor shift left or right decrements or increments the address. A display shift changes only the offset: left adds 1 and right subtracts 1, modulo 40 in two-line mode and modulo 80 in one-line mode.
- R7: With shift-on-write set, each display RAM write also shifts the display (left when incrementing, right when decrementing). Glyph RAM writes never shift.
- R8: Each RAM read or write steps the address by one in the entry-mode direction.
- R9: Busy lasts ceil(t·CLK_KHZ/1000) cycles, where t is 1530 µs for clear and home, 39 µs for the other instructions and 43 µs for RAM access. With the default of 270 kHz this gives 414, 11 and 12 cycles. A busy/address read adds no busy time.
- R10: While busy, every strobe except a busy/address read is ignored.
- R11: A data read returns a byte latched after the last address set, cursor shift or read. A write does not refresh that latch.
- R12: A busy/address read (select=0, read/write=1) returns {busy, address[6:0]} on the data output, which is updated on the clock edge that samples the strobe.
- R13: After reset the address is 00h in display RAM, the offset is 0, display, cursor and blink are off, one-line mode is set, increment is on, shift-on-write is off and busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Active-low synchronous reset |
| busStrobe | input | 1 | One-cycle access strobe |
| busRs | input | 1 | 0 = instruction/status, 1 = RAM data |
| busRw | input | 1 | 0 = write, 1 = read |
| busDin | input | 8 | Write data |
| busDout | output | 8 | Read data, registered |
| busyOut | output | 1 | Busy flag |
| displayOn | output | 1 | Display enable flag |
| cursorOn | output | 1 | Cursor visible flag |
| blinkOn | output | 1 | Cursor blink flag |
| twoLine | output | 1 | Two-line mode flag |
| shiftOfs | output | 7 | Display shift offset |

## Verification
The bound checker watches the following on every cycle:
- busy rises after each accepted command;
- a strobe arriving while busy leaves the address counter untouched;
- a busy read disturbs neither the address nor the offset;
- clear and home land on address 0 with offset 0;
- display shifts keep the address;
- the two-line increment and decrement wrap points hold.

Some behaviour can only be shown by the bench's sequences: the exact busy lengths, the stale value returned by a read that follows a write, the fill value left by clear, offset wrap and shift-on-write, and one-line and glyph address wrap.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  typedef struct packed {
    logic       doClear;
    logic       doHome;
    logic       doCursor;
    logic       doDisp;
    logic       setCg;
    logic       setDd;
    logic       wrRam;
    logic       rdRam;
    logic       rdBusy;
    logic       busyNow;
    logic       incMode;
    logic       shiftEn;
    logic       twoLine;
    logic [7:0] arg;
  } ctlStrobe_t;
endpackage

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
  import chardisp_pkg::*;
#(
  parameter int CLK_KHZ = 270
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busStrobe,
  input  logic       busRs,
  input  logic       busRw,
  input  logic [7:0] busDin,
  output ctlStrobe_t ctl,
  output logic       busyOut,
  output logic       displayOn,
  output logic       cursorOn,
  output logic       blinkOn,
  output logic       twoLine
);
  localparam int CLR_CYC = (1530 * CLK_KHZ + 999) / 1000;
  localparam int INS_CYC = (39 * CLK_KHZ + 999) / 1000;
  localparam int RAM_CYC = (43 * CLK_KHZ + 999) / 1000;
  localparam int CNT_W   = $clog2(CLR_CYC + 1);

  logic [CNT_W-1:0] busyCnt;
  logic incMode, shiftEn, accept, isInstr, doFunc, doDispCtl, doEntry;

  assign busyOut = (busyCnt != '0);
  assign accept  = busStrobe && (!busyOut || (!busRs && busRw));
  assign isInstr = accept && !busRs && !busRw;

  always_comb begin
    ctl = '0;
    doFunc = 1'b0;
    doDispCtl = 1'b0;
    doEntry = 1'b0;
    ctl.arg = busDin;
    ctl.busyNow = busyOut;
    ctl.incMode = incMode;
    ctl.shiftEn = shiftEn;
    ctl.twoLine = twoLine;
    ctl.wrRam = accept && busRs && !busRw;
    ctl.rdRam = accept && busRs && busRw;
    ctl.rdBusy = accept && !busRs && busRw;
    if (isInstr) begin
      casez (busDin)
        8'b1???????: ctl.setDd = 1'b1;
        8'b01??????: ctl.setCg = 1'b1;
        8'b001?????: doFunc = 1'b1;
        8'b0001????: begin
          ctl.doDisp = busDin[3];
          ctl.doCursor = !busDin[3];
        end
        8'b00001???: doDispCtl = 1'b1;
        8'b000001??: doEntry = 1'b1;
        8'b0000001?: ctl.doHome = 1'b1;
        8'b00000001: ctl.doClear = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      incMode <= 1'b1;
      shiftEn <= 1'b0;
      twoLine <= 1'b0;
      displayOn <= 1'b0;
      cursorOn <= 1'b0;
      blinkOn <= 1'b0;
    end else begin
      if (ctl.doClear || ctl.doHome) busyCnt <= CNT_W'(CLR_CYC);
      else if (isInstr && busDin != 8'h00) busyCnt <= CNT_W'(INS_CYC);
      else if (ctl.wrRam || ctl.rdRam) busyCnt <= CNT_W'(RAM_CYC);
      else if (busyOut) busyCnt <= busyCnt - 1'b1;
      if (ctl.doClear) incMode <= 1'b1;
      if (doEntry) begin
        incMode <= busDin[1];
        shiftEn <= busDin[0];
      end
      if (doFunc) twoLine <= busDin[3];
      if (doDispCtl) begin
        displayOn <= busDin[2];
        cursorOn <= busDin[1];
        blinkOn <= busDin[0];
      end
    end
  end
endmodule

// File: rtl/chardisp_dpath.sv
module chardisp_dpath
  import chardisp_pkg::*;
#(
  parameter int DD_BYTES = 80,
  parameter int CG_BYTES = 64,
  parameter int LINE_LEN = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output logic [7:0] busDout,
  output logic [6:0] shiftOfs,
  output logic [6:0] acNow,
  output logic       cgSel
);
  localparam int CG_W = $clog2(CG_BYTES);

  logic [7:0] ddram [DD_BYTES];
  logic [7:0] cgram [CG_BYTES];
  logic [7:0] dataLatch;
  logic       refillQ;
  logic [6:0] ddIdx;
  logic       idxOk;
  logic [7:0] rdVal;

  function automatic logic [6:0] stepAc(input logic [6:0] a, input logic up,
                                        input logic two, input logic cg);
    logic [6:0] r;
    if (cg) r = {{(7-CG_W){1'b0}}, up ? a[CG_W-1:0] + 1'b1 : a[CG_W-1:0] - 1'b1};
    else if (two) begin
      if (up) r = (a == 7'(LINE_LEN - 1)) ? 7'h40 : (a == 7'(64 + LINE_LEN - 1)) ? 7'h00 : a + 7'd1;
      else    r = (a == 7'h40) ? 7'(LINE_LEN - 1) : (a == 7'h00) ? 7'(64 + LINE_LEN - 1) : a - 7'd1;
    end else begin
      if (up) r = (a == 7'(DD_BYTES - 1)) ? 7'h00 : a + 7'd1;
      else    r = (a == 7'h00) ? 7'(DD_BYTES - 1) : a - 7'd1;
    end
    return r;
  endfunction

  function automatic logic [6:0] stepOfs(input logic [6:0] o, input logic left,
                                         input logic two);
    logic [6:0] top;
    top = two ? 7'(LINE_LEN - 1) : 7'(DD_BYTES - 1);
    if (left) return (o >= top) ? 7'd0 : o + 7'd1;
    return (o == 7'd0) ? top : o - 7'd1;
  endfunction

  assign ddIdx = (ctl.twoLine && acNow[6]) ? acNow - 7'(64 - LINE_LEN) : acNow;
  assign idxOk = (int'(ddIdx) < DD_BYTES);
  assign rdVal = cgSel ? cgram[acNow[CG_W-1:0]] : (idxOk ? ddram[ddIdx] : 8'h00);

  always_ff @(posedge clk) begin
    if (ctl.doClear) begin
      for (int i = 0; i < DD_BYTES; i++) ddram[i] <= 8'h20;
    end else if (ctl.wrRam && !cgSel && idxOk) begin
      ddram[ddIdx] <= ctl.arg;
    end
    if (ctl.wrRam && cgSel) cgram[acNow[CG_W-1:0]] <= ctl.arg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acNow <= '0;
      cgSel <= 1'b0;
      shiftOfs <= '0;
      dataLatch <= '0;
      refillQ <= 1'b0;
      busDout <= '0;
    end else begin
      refillQ <= ctl.setDd || ctl.setCg || ctl.doCursor || ctl.rdRam;
      if (refillQ) dataLatch <= rdVal;
      if (ctl.doClear || ctl.doHome) begin
        acNow <= '0;
        cgSel <= 1'b0;
        shiftOfs <= '0;
      end
      if (ctl.doCursor) acNow <= stepAc(acNow, ctl.arg[2], ctl.twoLine, cgSel);
      if (ctl.doDisp) shiftOfs <= stepOfs(shiftOfs, !ctl.arg[2], ctl.twoLine);
      if (ctl.setDd) begin
        acNow <= ctl.arg[6:0];
        cgSel <= 1'b0;
      end
      if (ctl.setCg) begin
        acNow <= {{(7-CG_W){1'b0}}, ctl.arg[CG_W-1:0]};
        cgSel <= 1'b1;
      end
      if (ctl.wrRam || ctl.rdRam) acNow <= stepAc(acNow, ctl.incMode, ctl.twoLine, cgSel);
      if (ctl.wrRam && !cgSel && ctl.shiftEn)
        shiftOfs <= stepOfs(shiftOfs, ctl.incMode, ctl.twoLine);
      if (ctl.rdRam) busDout <= dataLatch;
      if (ctl.rdBusy) busDout <= {ctl.busyNow, acNow};
    end
  end
endmodule

// File: rtl/chardisp_top.sv
module chardisp_top
  import chardisp_pkg::*;
#(
  parameter int CLK_KHZ  = 270,
  parameter int DD_BYTES = 80,
  parameter int CG_BYTES = 64,
  parameter int LINE_LEN = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busStrobe,
  input  logic       busRs,
  input  logic       busRw,
  input  logic [7:0] busDin,
  output logic [7:0] busDout,
  output logic       busyOut,
  output logic       displayOn,
  output logic       cursorOn,
  output logic       blinkOn,
  output logic       twoLine,
  output logic [6:0] shiftOfs
);
  ctlStrobe_t ctl;
  logic [6:0] acNow;
  logic       cgSel;

  chardisp_ctrl #(.CLK_KHZ(CLK_KHZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .busRs(busRs), .busRw(busRw),
    .busDin(busDin), .ctl(ctl), .busyOut(busyOut), .displayOn(displayOn),
    .cursorOn(cursorOn), .blinkOn(blinkOn), .twoLine(twoLine)
  );

  chardisp_dpath #(.DD_BYTES(DD_BYTES), .CG_BYTES(CG_BYTES), .LINE_LEN(LINE_LEN)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busDout(busDout), .shiftOfs(shiftOfs),
    .acNow(acNow), .cgSel(cgSel)
  );
endmodule

// File: rtl/chardisp_chk.sv
module chardisp_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busStrobe,
  input logic       busRs,
  input logic       busRw,
  input logic       busyOut,
  input logic       doClear,
  input logic       doHome,
  input logic       doDisp,
  input logic       wrRam,
  input logic       rdRam,
  input logic       twoLine,
  input logic       incMode,
  input logic       cgSel,
  input logic [6:0] acNow,
  input logic [6:0] shiftOfs
);
  p_busy_after_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doClear || doHome || wrRam || rdRam) |=> busyOut);

  p_ignore_when_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && busyOut && busRs) |=> $stable(acNow));

  p_busy_read_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && !busRs && busRw) |=> ($stable(acNow) && $stable(shiftOfs)));

  p_home_origin_r3: assert property (@(posedge clk) disable iff (!rstN)
    doHome |=> (acNow == 7'h00 && shiftOfs == 7'd0 && !cgSel));

  p_clear_origin_r2: assert property (@(posedge clk) disable iff (!rstN)
    doClear |=> (acNow == 7'h00 && shiftOfs == 7'd0 && !cgSel));

  p_disp_keeps_ac_r6: assert property (@(posedge clk) disable iff (!rstN)
    doDisp |=> $stable(acNow));

  p_wrap_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((wrRam || rdRam) && twoLine && incMode && !cgSel && acNow == 7'h27) |=> (acNow == 7'h40));

  p_wrap_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((wrRam || rdRam) && twoLine && !incMode && !cgSel && acNow == 7'h40) |=> (acNow == 7'h27));
endmodule

bind chardisp_top chardisp_chk u_chk (
  .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .busRs(busRs), .busRw(busRw),
  .busyOut(busyOut), .doClear(ctl.doClear), .doHome(ctl.doHome), .doDisp(ctl.doDisp),
  .wrRam(ctl.wrRam), .rdRam(ctl.rdRam), .twoLine(ctl.twoLine), .incMode(ctl.incMode),
  .cgSel(cgSel), .acNow(acNow), .shiftOfs(shiftOfs)
);

// File: tb/chardisp_top_tb.sv
module chardisp_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 48;
  // {rs, rw, chk, din, expected}
  localparam logic [18:0] VEC [NVEC] = '{
    {3'b000, 8'h01, 8'h00}, {3'b000, 8'h38, 8'h00}, {3'b000, 8'h06, 8'h00}, {3'b000, 8'h0F, 8'h00},
    {3'b000, 8'hA7, 8'h00}, {3'b100, 8'h41, 8'h00}, {3'b011, 8'h00, 8'h40}, {3'b100, 8'h42, 8'h00},
    {3'b000, 8'hA7, 8'h00}, {3'b111, 8'h00, 8'h41}, {3'b111, 8'h00, 8'h42}, {3'b000, 8'h04, 8'h00},
    {3'b000, 8'hC0, 8'h00}, {3'b111, 8'h00, 8'h42}, {3'b011, 8'h00, 8'h27}, {3'b000, 8'h80, 8'h00},
    {3'b000, 8'h10, 8'h00}, {3'b011, 8'h00, 8'h67}, {3'b000, 8'h14, 8'h00}, {3'b011, 8'h00, 8'h00},
    {3'b000, 8'h06, 8'h00}, {3'b000, 8'h85, 8'h00}, {3'b100, 8'h55, 8'h00}, {3'b000, 8'h84, 8'h00},
    {3'b111, 8'h00, 8'h20}, {3'b111, 8'h00, 8'h55}, {3'b100, 8'h66, 8'h00}, {3'b111, 8'h00, 8'h20},
    {3'b000, 8'h7F, 8'h00}, {3'b100, 8'h99, 8'h00}, {3'b011, 8'h00, 8'h00}, {3'b000, 8'h7F, 8'h00},
    {3'b111, 8'h00, 8'h99}, {3'b000, 8'hE7, 8'h00}, {3'b100, 8'h11, 8'h00}, {3'b011, 8'h00, 8'h00},
    {3'b000, 8'h02, 8'h00}, {3'b011, 8'h00, 8'h00}, {3'b000, 8'hC0, 8'h00}, {3'b111, 8'h00, 8'h42},
    {3'b000, 8'h30, 8'h00}, {3'b000, 8'hCF, 8'h00}, {3'b100, 8'h77, 8'h00}, {3'b011, 8'h00, 8'h00},
    {3'b000, 8'h04, 8'h00}, {3'b000, 8'h80, 8'h00}, {3'b100, 8'h12, 8'h00}, {3'b011, 8'h00, 8'h4F}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busStrobe = 1'b0, busRs = 1'b0, busRw = 1'b0;
  logic [7:0] busDin = 8'h00;
  logic [7:0] busDout;
  logic busyOut, displayOn, cursorOn, blinkOn, twoLine;
  logic [6:0] shiftOfs;
  int total = 0, bad = 0, cycles = 0;
  logic wdHit = 1'b0, done = 1'b0;

  chardisp_top u_dut (
    .clk(clk), .rstN(rstN), .busStrobe(busStrobe), .busRs(busRs), .busRw(busRw),
    .busDin(busDin), .busDout(busDout), .busyOut(busyOut), .displayOn(displayOn),
    .cursorOn(cursorOn), .blinkOn(blinkOn), .twoLine(twoLine), .shiftOfs(shiftOfs)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) wdHit <= 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic rs, input logic rw, input logic [7:0] d,
                      output logic [7:0] q, output int cyc);
    @(negedge clk);
    busRs = rs; busRw = rw; busDin = d; busStrobe = 1'b1;
    @(negedge clk);
    busStrobe = 1'b0;
    q = busDout;
    cyc = 0;
    while (busyOut && !wdHit) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    wait (wdHit);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 busy", busyOut, 0);
    check("R13 flags", {displayOn, cursorOn, blinkOn, twoLine}, 0);
    check("R13 offset", shiftOfs, 0);
    doOp(0, 1, 8'h00, q, n);
    check("R13/R12 address", q, 8'h00);
    check("R9 busy read adds none", n, 0);

    // R9 busy lengths
    doOp(0, 0, 8'h01, q, n); check("R9 clear cycles", n, 414);
    doOp(0, 0, 8'h02, q, n); check("R9 home cycles", n, 414);
    doOp(0, 0, 8'h06, q, n); check("R9 entry cycles", n, 11);
    doOp(1, 0, 8'h33, q, n); check("R9 write cycles", n, 12);
    doOp(0, 0, 8'h00, q, n); check("R1 zero byte no busy", n, 0);

    // R10 strobes while busy are ignored
    doOp(0, 0, 8'h01, q, n);
    @(negedge clk);
    busRs = 0; busRw = 0; busDin = 8'h01; busStrobe = 1'b1;
    @(negedge clk);
    busDin = 8'h85;
    @(negedge clk);
    busRs = 1; busDin = 8'hAB;
    @(negedge clk);
    busStrobe = 1'b0;
    while (busyOut && !wdHit) @(negedge clk);
    doOp(0, 1, 8'h00, q, n); check("R10 address untouched", q, 8'h00);
    doOp(0, 0, 8'h80, q, n);
    doOp(1, 1, 8'h00, q, n); check("R10 RAM untouched", q, 8'h20);

    // Table: R1 R2 R4 R5 R8 R11 R12
    for (int i = 0; i < NVEC; i++) begin
      doOp(VEC[i][18], VEC[i][17], VEC[i][15:8], q, n);
      if (VEC[i][16]) check($sformatf("R4/R5/R8/R11 vector %0d", i), q, VEC[i][7:0]);
    end
    check("R1 one-line mode", twoLine, 0);

    // R6 display shift and R7 shift on write
    doOp(0, 0, 8'h38, q, n); check("R1 two-line set", twoLine, 1);
    doOp(0, 0, 8'h02, q, n); check("R3 home offset", shiftOfs, 0);
    doOp(0, 0, 8'h1C, q, n); check("R6 right wrap", shiftOfs, 39);
    doOp(0, 0, 8'h18, q, n); check("R6 left wrap", shiftOfs, 0);
    doOp(0, 0, 8'h18, q, n); check("R6 left", shiftOfs, 1);
    doOp(0, 1, 8'h00, q, n); check("R6 address kept", q, 8'h00);
    doOp(0, 0, 8'h07, q, n);
    doOp(0, 0, 8'h80, q, n);
    doOp(1, 0, 8'h5A, q, n); check("R7 write shifts left", shiftOfs, 2);
    doOp(0, 0, 8'h40, q, n);
    doOp(1, 0, 8'h5B, q, n); check("R7 glyph write no shift", shiftOfs, 2);
    doOp(0, 0, 8'h05, q, n);
    doOp(0, 0, 8'h85, q, n);
    doOp(1, 0, 8'h5C, q, n); check("R7 write shifts right", shiftOfs, 1);
    doOp(0, 0, 8'h01, q, n); check("R2 clear offset", shiftOfs, 0);
    doOp(1, 0, 8'h5D, q, n);
    doOp(0, 1, 8'h00, q, n); check("R2 increment forced", q, 8'h01);
    doOp(0, 0, 8'hC0, q, n);
    doOp(1, 1, 8'h00, q, n); check("R2 fill value", q, 8'h20);

    // R1 display control
    doOp(0, 0, 8'h0C, q, n);
    check("R1 display control", {displayOn, cursorOn, blinkOn}, 3'b100);
    doOp(0, 0, 8'h00, q, n);
    check("R1 zero byte no change", {displayOn, cursorOn, blinkOn, twoLine}, 4'b1001);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule